// File: doc/BRIEF.md
# Self-Clearing Error Insertion Controller

This block keeps a small register of one-shot error insertion requests for a line framer. Each request bit stands for one kind of deliberate error, such as a corrupted framing bit or a wrong parity bit. A processor write can only raise request bits. A request then waits until the datapath reports a usable slot for that error kind.

When the datapath reports a usable slot, the block drives a one-clock insert pulse on the matching output and drops the request on its own. Software reads the register back and polls a bit until it reads 0 before it arms that error kind again. Any number of requests can be pending at once, and each one retires independently of the others.

The datapath supplies two inputs per error kind. One is a strobe that marks an insertion slot. The other is a flag that says whether the error kind is legal in the current line mode. A request for an error kind that is not legal does nothing and stays pending. A mask parameter marks some bit positions as unimplemented. These positions always read 0.

Top module: `errins_ctrl`

## Requirements
- R1: After reset, and in the cycles that follow it before any write, `cpu_rd_data` reads 0 and `err_insert` is 0.
- R2: A cycle with `cpu_wr_en` = 1 and bit i of `cpu_wr_data` = 1 makes bit i of `cpu_rd_data` read 1 from the next cycle onward, for every implemented bit i.
- R3: A 0 in bit i of a write leaves request bit i unchanged, whether it was 0 or 1.
- R4: `err_insert[i]` is 1 in exactly those cycles where request bit i reads 1, `err_opp[i]` = 1 and `err_valid[i]` = 1, all in that same cycle.
- R5: After a cycle with `err_insert[i]` = 1 and no write setting bit i, request bit i reads 0.
- R6: An insertion clears only its own request bit. The other pending bits keep their values.
- R7: While `err_valid[i]` = 0, request bit i causes no insert pulse and stays set, even when `err_opp[i]` = 1.
- R8: If a write sets bit i in the same cycle that bit i is inserted, bit i still reads 1 in the next cycle and waits for the next slot.
- R9: A bit position whose bit in the parameter `IMPL_MASK` is 0 is reserved. It always reads 0 and never pulses, whatever is written. The default is 8 bits with mask 0x7F, so bit 7 is reserved.
- R10: A single arm produces exactly one insert pulse, even if the slot strobe stays high for several cycles. This means `err_insert[i]` is high in two cycles in a row only when bit i was written in the first of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Its release is synchronised inside the block. |
| cpu_wr_en | input | 1 | Write strobe for the request register |
| cpu_wr_data | input | NUM_ERR | Write data. A 1 arms a bit and a 0 has no effect. |
| cpu_rd_data | output | NUM_ERR | Pending request bits. Reserved positions read 0. |
| err_opp | input | NUM_ERR | Per-kind insertion slot strobe from the datapath |
| err_valid | input | NUM_ERR | Per-kind flag: the error kind is legal in the current mode |
| err_insert | output | NUM_ERR | Per-kind one-clock insert command |

## Verification
The insert pulse is combinational from the pending register. It is therefore due in the same cycle as the slot strobe that triggers it. A write or a retirement shows on `cpu_rd_data` one clock after the edge that samples it. The bench changes inputs just after a rising edge and compares both outputs with its reference model at the falling edge of the same cycle. It then advances the model's pending state, so every comparison lands in the cycle where the result is due. The two-stage reset release means the first write is only applied after several idle cycles. During these cycles the model expects zeros, which covers R1.

// File: rtl/errins_pkg.sv
package errins_pkg;
  // Default number of request positions and the default implemented mask.
  localparam int unsigned ERRINS_DEF_NUM  = 8;
  localparam logic [7:0]  ERRINS_DEF_MASK = 8'h7F;

  // Number of reset-release synchroniser stages.
  localparam int unsigned ERRINS_SYNC_STAGES = 2;

  // Decoded action applied to one request cell in a cycle.
  typedef enum logic [1:0] {
    CELL_HOLD   = 2'b00,
    CELL_RETIRE = 2'b01,
    CELL_ARM    = 2'b10,
    CELL_REARM  = 2'b11
  } cell_act_e;

  function automatic cell_act_e cell_action(input logic arm, input logic fire);
    return cell_act_e'({arm, fire});
  endfunction
endpackage

// File: rtl/errins_rst_sync.sv
module errins_rst_sync #(
  parameter int unsigned STAGES = errins_pkg::ERRINS_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/errins_req_cell.sv
module errins_req_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic opp_i,
  input  logic valid_i,
  output logic pend_o,
  output logic fire_o
);
  import errins_pkg::*;

  logic      pend_q;
  logic      pend_d;
  logic      pend_en;
  logic      fire;
  cell_act_e act;

  // An insertion happens only on a legal slot while armed.
  assign fire = pend_q & opp_i & valid_i;
  assign act  = cell_action(arm_i, fire);

  always_comb begin
    pend_d  = pend_q;
    pend_en = 1'b0;
    unique case (act)
      CELL_HOLD:   begin pend_d = pend_q; pend_en = 1'b0; end
      CELL_RETIRE: begin pend_d = 1'b0;   pend_en = 1'b1; end
      CELL_ARM:    begin pend_d = 1'b1;   pend_en = 1'b1; end
      CELL_REARM:  begin pend_d = 1'b1;   pend_en = 1'b1; end
      default:     begin pend_d = pend_q; pend_en = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
  assign fire_o = fire;
endmodule

// File: rtl/errins_ctrl.sv
module errins_ctrl #(
  parameter int unsigned          NUM_ERR   = errins_pkg::ERRINS_DEF_NUM,
  parameter logic [NUM_ERR-1:0]   IMPL_MASK = NUM_ERR'(errins_pkg::ERRINS_DEF_MASK)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_wr_en,
  input  logic [NUM_ERR-1:0] cpu_wr_data,
  output logic [NUM_ERR-1:0] cpu_rd_data,
  input  logic [NUM_ERR-1:0] err_opp,
  input  logic [NUM_ERR-1:0] err_valid,
  output logic [NUM_ERR-1:0] err_insert
);
  localparam int unsigned IMPL_CNT = $countones(IMPL_MASK);

  logic               rst_q_n;
  logic [NUM_ERR-1:0] arm_vec;
  logic [NUM_ERR-1:0] pend_vec;
  logic [NUM_ERR-1:0] fire_vec;

  errins_rst_sync #(
    .STAGES (errins_pkg::ERRINS_SYNC_STAGES)
  ) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  // A write only ever raises bits; zeros in the data are no-ops.
  always_comb begin
    arm_vec = cpu_wr_en ? (cpu_wr_data & IMPL_MASK) : '0;
  end

  for (genvar gi = 0; gi < NUM_ERR; gi++) begin : g_bit
    if (IMPL_MASK[gi]) begin : g_impl
      errins_req_cell u_cell (
        .clk     (clk),
        .rst_n   (rst_q_n),
        .arm_i   (arm_vec[gi]),
        .opp_i   (err_opp[gi]),
        .valid_i (err_valid[gi]),
        .pend_o  (pend_vec[gi]),
        .fire_o  (fire_vec[gi])
      );
    end else begin : g_rsvd
      logic unused_rsvd;
      assign unused_rsvd  = err_opp[gi] ^ err_valid[gi] ^ arm_vec[gi];
      assign pend_vec[gi] = 1'b0;
      assign fire_vec[gi] = 1'b0;
    end
  end

  if (IMPL_CNT == 0) begin : g_none
    logic unused_wr;
    assign unused_wr = cpu_wr_en;
  end

  assign cpu_rd_data = pend_vec;
  assign err_insert  = fire_vec;
endmodule

// File: rtl/errins_chk.sv
module errins_chk #(
  parameter int unsigned        NUM_ERR   = 8,
  parameter logic [NUM_ERR-1:0] IMPL_MASK = '1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_wr_en,
  input logic [NUM_ERR-1:0] cpu_wr_data,
  input logic [NUM_ERR-1:0] cpu_rd_data,
  input logic [NUM_ERR-1:0] err_opp,
  input logic [NUM_ERR-1:0] err_valid,
  input logic [NUM_ERR-1:0] err_insert
);
  logic [NUM_ERR-1:0] set_now;
  assign set_now = cpu_wr_en ? (cpu_wr_data & IMPL_MASK) : '0;

  AST_FIRE_ON_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_insert & ~(err_opp & cpu_rd_data)) == '0)); // R4

  AST_NO_INVALID_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_insert & ~err_valid) == '0)); // R7

  AST_ARM_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr_en |=> ((cpu_rd_data & $past(set_now)) == $past(set_now))); // R2

  AST_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_insert != '0) |=> ((cpu_rd_data & $past(err_insert) & ~$past(set_now)) == '0)); // R5

  AST_HOLD_UNFIRED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd_data != '0) |=> (($past(cpu_rd_data) & ~$past(err_insert) & ~cpu_rd_data) == '0)); // R6

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (((cpu_rd_data | err_insert) & ~IMPL_MASK) == '0)); // R9

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_insert != '0) |=> ((err_insert & $past(err_insert) & ~$past(set_now)) == '0)); // R10
endmodule

bind errins_ctrl errins_chk #(
  .NUM_ERR   (NUM_ERR),
  .IMPL_MASK (IMPL_MASK)
) u_errins_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .cpu_wr_en   (cpu_wr_en),
  .cpu_wr_data (cpu_wr_data),
  .cpu_rd_data (cpu_rd_data),
  .err_opp     (err_opp),
  .err_valid   (err_valid),
  .err_insert  (err_insert)
);

// File: tb/tb_errins_ctrl.sv
`timescale 1ns/1ps
module tb_errins_ctrl;
  localparam int N = 8;
  localparam logic [N-1:0] MASK = 8'h7F;

  logic         clk;
  logic         rst_n;
  logic         cpu_wr_en;
  logic [N-1:0] cpu_wr_data;
  logic [N-1:0] cpu_rd_data;
  logic [N-1:0] err_opp;
  logic [N-1:0] err_valid;
  logic [N-1:0] err_insert;

  int    checks;
  int    failures;
  bit    done;
  bit    model_on;
  string phase;
  logic [N-1:0] m_pend;

  errins_ctrl dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_wr_en   (cpu_wr_en),
    .cpu_wr_data (cpu_wr_data),
    .cpu_rd_data (cpu_rd_data),
    .err_opp     (err_opp),
    .err_valid   (err_valid),
    .err_insert  (err_insert)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model: compare at the falling edge, then advance for the next rising edge.
  always @(negedge clk) begin
    if (model_on && !done) begin
      logic [N-1:0] e_ins;
      logic [N-1:0] setv;
      e_ins = m_pend & err_opp & err_valid & MASK;
      check(phase, cpu_rd_data, m_pend, "rd_data");
      check(phase, err_insert, e_ins, "insert");
      setv = cpu_wr_en ? (cpu_wr_data & MASK) : '0;
      m_pend = (m_pend & ~e_ins) | setv;
    end
  end

  task automatic cyc(input logic wr, input logic [N-1:0] wd, input logic [N-1:0] op,
                     input logic [N-1:0] vl);
    @(posedge clk);
    #1;
    cpu_wr_en   = wr;
    cpu_wr_data = wd;
    err_opp     = op;
    err_valid   = vl;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    checks = 0; failures = 0; done = 1'b0; model_on = 1'b0;
    m_pend = '0; phase = "R1";
    rst_n = 1'b0; cpu_wr_en = 1'b0; cpu_wr_data = '0; err_opp = '0; err_valid = '0;
    #2 model_on = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: idle cycles through reset release with slots offered
    for (int k = 0; k < 5; k++) cyc(1'b0, '0, 8'hFF, 8'hFF);
    @(negedge clk); #1;
    check("R1", cpu_rd_data, '0, "reset value");

    phase = "R2";
    cyc(1'b1, 8'h05, '0, 8'hFF);
    cyc(1'b0, '0, '0, 8'hFF);
    @(negedge clk); #1;
    check("R2", cpu_rd_data, 8'h05, "armed bits");

    phase = "R3";
    cyc(1'b1, 8'h00, '0, 8'hFF);
    cyc(1'b1, 8'h02, '0, 8'hFF);
    cyc(1'b0, '0, '0, 8'hFF);
    @(negedge clk); #1;
    check("R3", cpu_rd_data, 8'h07, "zero writes keep bits");

    phase = "R4";
    cyc(1'b0, '0, 8'h01, 8'hFF);
    @(negedge clk); #1;
    check("R4", err_insert, 8'h01, "pulse on slot");
    phase = "R5";
    cyc(1'b0, '0, '0, 8'hFF);
    @(negedge clk); #1;
    check("R5", cpu_rd_data, 8'h06, "bit retired");

    phase = "R6";
    cyc(1'b0, '0, 8'h04, 8'hFF);
    cyc(1'b0, '0, '0, 8'hFF);
    @(negedge clk); #1;
    check("R6", cpu_rd_data, 8'h02, "other bit kept");

    phase = "R7";
    for (int k = 0; k < 4; k++) cyc(1'b0, '0, 8'h02, 8'hFD);
    @(negedge clk); #1;
    check("R7", err_insert, 8'h00, "no pulse when illegal");
    check("R7", cpu_rd_data, 8'h02, "illegal request stays");
    cyc(1'b0, '0, 8'h02, 8'hFF);
    cyc(1'b0, '0, '0, 8'hFF);

    phase = "R8";
    cyc(1'b1, 8'h08, '0, 8'hFF);
    cyc(1'b1, 8'h08, 8'h08, 8'hFF);
    cyc(1'b0, '0, '0, 8'hFF);
    @(negedge clk); #1;
    check("R8", cpu_rd_data, 8'h08, "rearm kept over insertion");
    cyc(1'b0, '0, 8'h08, 8'hFF);
    cyc(1'b0, '0, '0, 8'hFF);

    phase = "R10";
    cyc(1'b1, 8'h10, '0, 8'hFF);
    cyc(1'b0, '0, 8'h10, 8'hFF);
    cyc(1'b0, '0, 8'h10, 8'hFF);
    @(negedge clk); #1;
    check("R10", err_insert, 8'h00, "single pulse for held slot");
    cyc(1'b0, '0, 8'h10, 8'hFF);

    phase = "R9";
    cyc(1'b1, 8'hFF, '0, 8'hFF);
    cyc(1'b0, '0, '0, 8'hFF);
    @(negedge clk); #1;
    check("R9", cpu_rd_data, 8'h7F, "reserved bit reads 0");
    cyc(1'b0, '0, 8'hFF, 8'hFF);
    @(negedge clk); #1;
    check("R9", err_insert & ~MASK, 8'h00, "reserved never pulses");
    cyc(1'b0, '0, '0, 8'hFF);

    phase = "R4 random";
    for (int k = 0; k < 400; k++) begin
      cyc(1'($urandom_range(0, 3) == 0), 8'($urandom), 8'($urandom), 8'($urandom));
    end
    cyc(1'b0, '0, '0, '0);
    cyc(1'b0, '0, '0, '0);
    finish_run();
  end
endmodule